// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts activity inside an accelerator for software that profiles it. It keeps four 32-bit event counters and one 48-bit cycle counter. Each event counter has a select register naming which line of a vector of one-cycle event strobes it adds up. The cycle counter runs only inside a window: one chosen event number opens the window and another closes it. Software reaches all state through a 32-bit register port with a combinational read path. A read strobe marks reads that have a side effect.

Counter enables, overflow flags and interrupt enables are each held in one register. Software changes that register through a pair of addresses, one that sets bits and one that clears them. In each pair, bit k stands for event counter k and bit 31 stands for the cycle counter. A level interrupt is raised while any flagged overflow has its interrupt enabled. Two self-clearing strobes in the control register zero the event counters or the cycle counter.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset all counters, enables, overflow flags, interrupt enables, event selects and window events are zero, and `irq` is low.
- R2: Control register (0x180): bit 0 is the global count enable and reads back. Bits 15:11 read the number of event counters (4). Bits 1 and 2 always read 0.
- R3: Counter enable register: writing 1s at 0x188 sets bits and writing 1s at 0x18C clears them. Both addresses read the current state. Only bits 3:0 and bit 31 exist; all other bits read 0.
- R4: An event counter adds 1 at each clock edge where its selected strobe is high, the global enable is 1 and its own enable bit is 1. An event number of 64 or more never counts.
- R5: Event counter k is read and written at 0x300+4k. Its 10-bit event select is read and written at 0x380+4k. A written value takes effect over a count in the same cycle.
- R6: The 48-bit cycle counter is written and read as a low word (0x1A0) and a high word (0x1A4, bits 15:0, upper bits read 0).
- R7: Window register (0x184): start event in bits 9:0, stop event in bits 25:16. The edge that sees the start strobe opens the window. The cycle counter then adds 1 at every later edge up to and including the edge that sees the stop strobe, provided the global enable and enable bit 31 are set. If start and stop come together, stop wins.
- R8: An event counter wrapping from 0xFFFFFFFF to 0, or the cycle counter wrapping from 2^48-1 to 0, sets its overflow flag. Flags are set by 1s written at 0x198, cleared by 1s written at 0x19C, and read at either address. Bits that do not exist ignore writes.
- R9: Interrupt enables are set at 0x190, cleared at 0x194, and read at either address. `irq` is high exactly while some bit is both flagged and enabled.
- R10: Writing 1 to control bit 1 zeroes every event counter, and writing 1 to bit 2 zeroes the cycle counter, at that edge. Each of these wins over a count in the same cycle.
- R11: Reading the low cycle word captures the high word at the same edge. A later read of the high word returns that captured value, even while counting continues.
- R12: Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 64 | One-cycle event strobes, bit n is event number n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the low-word capture) |
| reg_addr | input | 10 | Byte address inside the unit |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the two wraps, because a counter cannot be run up to all ones in useful time. The stimulus preloads the counters through the write port, just below all ones. For the cycle counter it then opens and closes the window so that the final increment falls exactly on the stop edge. The coherent 48-bit read is driven while the window is open and the low word is one step from carrying. The test checks that the high word read afterward still holds the value captured before the carry, and that a fresh low-word read picks up the new value.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int N_CNT      = 4,
  parameter int NUM_EVENTS = 64,
  parameter int CYC_W      = 48,
  parameter int EVT_W      = 10,
  parameter int ADDR_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] evt_strobe,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq
);

  localparam int HI_W = CYC_W - 32;
  localparam logic [31:0] VALID = (32'h1 << 31) | ((32'h1 << N_CNT) - 32'h1);
  localparam logic [4:0]  NC5   = 5'(N_CNT);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'('h180);
  localparam logic [ADDR_W-1:0] A_WIN    = ADDR_W'('h184);
  localparam logic [ADDR_W-1:0] A_ENS    = ADDR_W'('h188);
  localparam logic [ADDR_W-1:0] A_ENC    = ADDR_W'('h18C);
  localparam logic [ADDR_W-1:0] A_IES    = ADDR_W'('h190);
  localparam logic [ADDR_W-1:0] A_IEC    = ADDR_W'('h194);
  localparam logic [ADDR_W-1:0] A_OVS    = ADDR_W'('h198);
  localparam logic [ADDR_W-1:0] A_OVC    = ADDR_W'('h19C);
  localparam logic [ADDR_W-1:0] A_CYLO   = ADDR_W'('h1A0);
  localparam logic [ADDR_W-1:0] A_CYHI   = ADDR_W'('h1A4);
  localparam int                CNT_BASE = 'h300;
  localparam int                SEL_BASE = 'h380;

  function automatic logic evt_fire(input logic [EVT_W-1:0] n,
                                    input logic [NUM_EVENTS-1:0] v);
    logic f;
    f = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++)
      if (n == EVT_W'(i)) f = v[i];
    return f;
  endfunction

  logic                  gen_en;
  logic [31:0]           en_q, ovf_q, ie_q;
  logic [CYC_W-1:0]      cyc_q;
  logic [HI_W-1:0]       hi_shadow;
  logic                  run_q;
  logic [EVT_W-1:0]      start_sel, stop_sel;
  logic [N_CNT-1:0][31:0]      cnt_v;
  logic [N_CNT-1:0][EVT_W-1:0] sel_v;
  logic [N_CNT-1:0]      ev_wrap;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_win  = reg_wr && reg_addr == A_WIN;
  wire wr_lo   = reg_wr && reg_addr == A_CYLO;
  wire wr_hi   = reg_wr && reg_addr == A_CYHI;
  wire ev_rst  = wr_ctrl && reg_wdata[1];
  wire cy_rst  = wr_ctrl && reg_wdata[2];

  wire [31:0] ens_m = (reg_wr && reg_addr == A_ENS) ? reg_wdata : 32'h0;
  wire [31:0] enc_m = (reg_wr && reg_addr == A_ENC) ? reg_wdata : 32'h0;
  wire [31:0] ies_m = (reg_wr && reg_addr == A_IES) ? reg_wdata : 32'h0;
  wire [31:0] iec_m = (reg_wr && reg_addr == A_IEC) ? reg_wdata : 32'h0;
  wire [31:0] ovs_m = (reg_wr && reg_addr == A_OVS) ? reg_wdata : 32'h0;
  wire [31:0] ovc_m = (reg_wr && reg_addr == A_OVC) ? reg_wdata : 32'h0;

  wire start_hit = evt_fire(start_sel, evt_strobe);
  wire stop_hit  = evt_fire(stop_sel, evt_strobe);
  wire cyc_inc   = gen_en && en_q[31] && run_q;
  wire cyc_wrap  = cyc_inc && (&cyc_q) && !cy_rst && !wr_lo && !wr_hi;

  wire [31:0] wrap_vec = {cyc_wrap, {(31-N_CNT){1'b0}}, ev_wrap};

  assign irq = |(ovf_q & ie_q);

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    logic [31:0]      cnt_r;
    logic [EVT_W-1:0] sel_r;
    wire wr_cnt = reg_wr && reg_addr == ADDR_W'(CNT_BASE + 4*k);
    wire wr_sel = reg_wr && reg_addr == ADDR_W'(SEL_BASE + 4*k);
    wire inc    = gen_en && en_q[k] && evt_fire(sel_r, evt_strobe);

    assign ev_wrap[k] = inc && (&cnt_r) && !wr_cnt && !ev_rst;
    assign cnt_v[k]   = cnt_r;
    assign sel_v[k]   = sel_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_r <= '0;
        sel_r <= '0;
      end else begin
        if (ev_rst)      cnt_r <= '0;
        else if (wr_cnt) cnt_r <= reg_wdata;
        else if (inc)    cnt_r <= cnt_r + 32'd1;
        if (wr_sel)      sel_r <= reg_wdata[EVT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en    <= 1'b0;
      en_q      <= '0;
      ovf_q     <= '0;
      ie_q      <= '0;
      start_sel <= '0;
      stop_sel  <= '0;
      run_q     <= 1'b0;
    end else begin
      if (wr_ctrl) gen_en <= reg_wdata[0];
      if (wr_win) begin
        start_sel <= reg_wdata[EVT_W-1:0];
        stop_sel  <= reg_wdata[16 +: EVT_W];
      end
      en_q  <= ((en_q | ens_m) & ~enc_m) & VALID;
      ie_q  <= ((ie_q | ies_m) & ~iec_m) & VALID;
      ovf_q <= ((ovf_q & ~ovc_m) | ovs_m | wrap_vec) & VALID;
      if (stop_hit)       run_q <= 1'b0;
      else if (start_hit) run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      hi_shadow <= '0;
    end else begin
      if (cy_rst) cyc_q <= '0;
      else if (wr_lo || wr_hi) begin
        if (wr_lo) cyc_q[31:0]       <= reg_wdata;
        if (wr_hi) cyc_q[CYC_W-1:32] <= reg_wdata[HI_W-1:0];
      end else if (cyc_inc) cyc_q <= cyc_q + CYC_W'(1);
      if (reg_rd && reg_addr == A_CYLO) hi_shadow <= cyc_q[CYC_W-1:32];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:        reg_rdata = {16'h0, NC5, 10'h0, gen_en};
      A_WIN: begin
        reg_rdata[EVT_W-1:0]  = start_sel;
        reg_rdata[16 +: EVT_W] = stop_sel;
      end
      A_ENS, A_ENC:  reg_rdata = en_q;
      A_IES, A_IEC:  reg_rdata = ie_q;
      A_OVS, A_OVC:  reg_rdata = ovf_q;
      A_CYLO:        reg_rdata = cyc_q[31:0];
      A_CYHI:        reg_rdata[HI_W-1:0] = hi_shadow;
      default:       reg_rdata = '0;
    endcase
    for (int k = 0; k < N_CNT; k++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + 4*k)) reg_rdata = cnt_v[k];
      if (reg_addr == ADDR_W'(SEL_BASE + 4*k)) reg_rdata = 32'(sel_v[k]);
    end
  end

endmodule

// File: rtl/perf_counter_unit_chk.sv
module perf_counter_unit_chk #(
  parameter int CYC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             irq,
  input logic             gen_en,
  input logic             run_q,
  input logic             ev_rst,
  input logic [31:0]      cnt0,
  input logic [CYC_W-1:0] cyc,
  input logic [31:0]      ovf,
  input logic [31:0]      ie
);

  // R10
  ev_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst |=> cnt0 == 32'h0);

  // R4
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !reg_wr) |=> $stable(cnt0));

  // R7
  window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_wr) |=> $stable(cyc));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !reg_wr) |=> ovf[0]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 32'h0) |-> !irq);

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(gen_en));

endmodule

bind perf_counter_unit perf_counter_unit_chk #(.CYC_W(CYC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .irq(irq), .gen_en(gen_en),
  .run_q(run_q), .ev_rst(ev_rst), .cnt0(cnt_v[0]), .cyc(cyc_q),
  .ovf(ovf_q), .ie(ie_q)
);

// File: tb/perf_counter_unit_tb_top.sv
`timescale 1ns/1ps
module perf_counter_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_strobe = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  perf_counter_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, v, exp);
  endtask

  task automatic pulse(input logic [63:0] v, input int times);
    for (int i = 0; i < times; i++) begin
      evt_strobe = v;
      @(negedge clk);
    end
    evt_strobe = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, R2 counter-number field
    rchk("R2", 10'h180, 32'h0000_2000);
    rchk("R1", 10'h184, 0);
    rchk("R1", 10'h188, 0);
    rchk("R1", 10'h190, 0);
    rchk("R1", 10'h198, 0);
    rchk("R1", 10'h1A0, 0);
    rchk("R1", 10'h1A4, 0);
    for (int k = 0; k < 4; k++) begin
      rchk("R1", 10'(32'h300 + 4*k), 0);
      rchk("R1", 10'(32'h380 + 4*k), 0);
    end
    chk("R1", {31'h0, irq}, 0);

    // R2 control readback, strobe bits read zero
    wr(10'h180, 32'h7);
    rchk("R2", 10'h180, 32'h0000_2001);

    // R3 enable set/clear pair
    wr(10'h188, 32'hFFFF_FFFF);
    rchk("R3", 10'h188, 32'h8000_000F);
    rchk("R3", 10'h18C, 32'h8000_000F);
    wr(10'h18C, 32'h0000_0005);
    rchk("R3", 10'h188, 32'h8000_000A);
    wr(10'h18C, 32'hFFFF_FFFF);
    rchk("R3", 10'h188, 0);

    // R4/R5 sweep: one counter enabled at a time, all selected events pulsed
    for (int k = 0; k < 4; k++) begin
      logic [63:0] v;
      v = '0;
      for (int j = 0; j < 4; j++) begin
        wr(10'(32'h380 + 4*j), 32'(j*5 + 3));
        v[j*5+3] = 1'b1;
      end
      wr(10'h180, 32'h3);
      wr(10'h18C, 32'hFFFF_FFFF);
      wr(10'h188, 32'h1 << k);
      pulse(v, k + 2);
      for (int j = 0; j < 4; j++)
        rchk("R4", 10'(32'h300 + 4*j), (j == k) ? 32'(k + 2) : 32'h0);
    end
    rchk("R5", 10'h38C, 32'd18);

    // R4 global enable off stops everything
    wr(10'h188, 32'h0000_000F);
    wr(10'h180, 32'h2);
    pulse(64'hFFFF_FFFF_FFFF_FFFF, 3);
    rchk("R4", 10'h300, 0);
    rchk("R4", 10'h30C, 0);
    wr(10'h180, 32'h1);

    // R4 last valid event counts, out-of-range event never counts
    wr(10'h380, 32'd63);
    pulse(64'h8000_0000_0000_0000, 2);
    rchk("R4", 10'h300, 2);
    wr(10'h380, 32'd64);
    pulse(64'hFFFF_FFFF_FFFF_FFFF, 3);
    rchk("R4", 10'h300, 2);

    // R5 direct writes, select width
    wr(10'h304, 32'hDEAD_BEEF);
    rchk("R5", 10'h304, 32'hDEAD_BEEF);
    wr(10'h384, 32'h0000_FFFF);
    rchk("R5", 10'h384, 32'h0000_03FF);
    wr(10'h384, 32'd8);
    wr(10'h18C, 32'hFFFF_FFFF);

    // R6 cycle counter words
    wr(10'h1A4, 32'hFFFF_ABCD);
    wr(10'h1A0, 32'h1234_5678);
    rchk("R6", 10'h1A0, 32'h1234_5678);
    rchk("R6", 10'h1A4, 32'h0000_ABCD);

    // R7 start/stop window
    wr(10'h184, (32'd9 << 16) | 32'd5);
    rchk("R7", 10'h184, 32'h0009_0005);
    wr(10'h180, 32'h5);
    wr(10'h188, 32'h8000_0000);
    idle(10);
    rchk("R7", 10'h1A0, 0);
    pulse(64'h1 << 5, 1);
    idle(4);
    pulse(64'h1 << 9, 1);
    idle(6);
    rchk("R7", 10'h1A0, 5);
    pulse((64'h1 << 5) | (64'h1 << 9), 1);
    idle(3);
    rchk("R7", 10'h1A0, 5);

    // R8 cycle counter wrap at 48 bits
    wr(10'h1A4, 32'h0000_FFFF);
    wr(10'h1A0, 32'hFFFF_FFFE);
    pulse(64'h1 << 5, 1);
    idle(1);
    pulse(64'h1 << 9, 1);
    rchk("R8", 10'h1A0, 0);
    rchk("R8", 10'h1A4, 0);
    rchk("R8", 10'h198, 32'h8000_0000);

    // R8 event counter wrap at 32 bits
    wr(10'h308, 32'hFFFF_FFFE);
    wr(10'h188, 32'h0000_0004);
    pulse(64'h1 << 13, 2);
    rchk("R8", 10'h308, 0);
    rchk("R8", 10'h19C, 32'h8000_0004);
    wr(10'h19C, 32'h0000_0004);
    rchk("R8", 10'h198, 32'h8000_0000);
    wr(10'h198, 32'h0000_0101);
    rchk("R8", 10'h198, 32'h8000_0001);
    wr(10'h18C, 32'hFFFF_FFFF);

    // R9 interrupt sweep over every existing bit
    wr(10'h19C, 32'hFFFF_FFFF);
    wr(10'h194, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] b;
      b = (i == 4) ? 32'h8000_0000 : (32'h1 << i);
      wr(10'h198, b);
      chk("R9", {31'h0, irq}, 0);
      wr(10'h190, b);
      chk("R9", {31'h0, irq}, 1);
      wr(10'h194, b);
      chk("R9", {31'h0, irq}, 0);
      wr(10'h190, b);
      wr(10'h19C, b);
      chk("R9", {31'h0, irq}, 0);
      wr(10'h194, b);
    end
    wr(10'h190, 32'hFFFF_FFFF);
    rchk("R9", 10'h194, 32'h8000_000F);
    chk("R9", {31'h0, irq}, 0);
    wr(10'h194, 32'hFFFF_FFFF);

    // R10 event reset wins over a same-cycle count
    wr(10'h380, 32'd3);
    wr(10'h188, 32'h1);
    wr(10'h300, 32'd5);
    evt_strobe = 64'h1 << 3;
    wr(10'h180, 32'h3);
    evt_strobe = '0;
    rchk("R10", 10'h300, 0);
    pulse(64'h1 << 3, 2);
    rchk("R10", 10'h300, 2);

    // R10 cycle reset wins over a running count
    wr(10'h188, 32'h8000_0000);
    pulse(64'h1 << 5, 1);
    idle(2);
    wr(10'h180, 32'h5);
    rchk("R10", 10'h1A0, 0);
    pulse(64'h1 << 9, 1);
    rchk("R10", 10'h1A0, 2);

    // R11 coherent high word across a carry
    wr(10'h1A4, 32'h1);
    wr(10'h1A0, 32'hFFFF_FFFF);
    pulse(64'h1 << 5, 1);
    rchk("R11", 10'h1A0, 32'hFFFF_FFFF);
    rchk("R11", 10'h1A4, 32'h1);
    pulse(64'h1 << 9, 1);
    rchk("R11", 10'h1A0, 32'h2);
    rchk("R11", 10'h1A4, 32'h2);

    // R12 unmapped addresses
    rchk("R12", 10'h1FC, 0);
    rchk("R12", 10'h310, 0);
    rchk("R12", 10'h390, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule